// File: doc/BRIEF.md
# SPI Motor-Controller Command Slave

This block is the register front end between a host microcontroller and the motor-control logic. It is an SPI mode-0 slave. Every transaction starts with chip select going low, and the first byte the host shifts in is a command. A read command is followed by a fixed telemetry frame on MISO. A write command is followed by a fixed setpoint frame on MOSI. The setpoint frame is unpacked into per-motor speeds and drive modes, dribbler settings and kicker controls.

All SPI pins are sampled with the fast system clock through synchronizers, so the block has a single clock domain. Telemetry inputs are copied into a snapshot when chip select goes low, so every byte of one frame comes from the same instant. Setpoints are collected in a shadow store. They reach the outputs only when a write frame completes. A frame that is cut short by chip select rising leaves the outputs as they were.

Top module: `spi_mc_slave`

## Requirements
- R1: After reset, every setpoint output is zero and MISO is low.
- R2: With command 0x00, the 17 bytes that follow the command come out MSB first in this order: 0x04, then each of the four 16-bit encoder counts (low byte, then high byte), then motor fault, kicker status, kicker voltage, and the five hall counts in index order.
- R3: MISO is low during the command byte, during every read byte after the 17th, and while chip select is high.
- R4: In a 0x01 frame, drive motor m (0..3) uses data bytes 2m and 2m+1, where data byte 0 is the byte after the command. Speed is {byte 2m+1 bits 1..0, byte 2m}, drive mode is byte 2m+1 bits 3..2, and bits 7..4 of byte 2m+1 have no effect.
- R5: Data bytes 8 and 9 give the dribbler speed and mode in the same layout. Byte 9 bit 7 is kicker charge and bit 6 is chip select (1 = chip, 0 = kick). Bits 5..4 have no effect. Data byte 10 is the kicker power.
- R6: Outputs change only once all 12 bytes of a 0x01 frame (command included) have arrived. Bytes after the 12th are ignored.
- R7: If chip select rises before the 12th byte, the frame is dropped and the outputs keep their values.
- R8: Telemetry is captured when chip select falls. Input changes after that point do not appear in the frame being read.
- R9: A command other than 0x00 or 0x01 returns zeros on MISO and leaves the outputs unchanged.
- R10: MOSI is sampled on SCK rising edges and MISO changes after SCK falling edges. The MSB of each response byte is valid before that byte's first rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock (idles low) |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Host-to-slave data |
| miso | output | 1 | Slave-to-host data |
| enc_counts | input | 64 | Four 16-bit encoder counts, encoder e at [16e+15:16e] |
| motor_fault | input | 8 | Motor fault flags |
| kick_status | input | 8 | Kicker status |
| kick_volt | input | 8 | Kicker voltage reading |
| hall_counts | input | 40 | Five 8-bit hall counts, hall h at [8h+7:8h] |
| motor_speed | output | 40 | Four 10-bit speeds, motor m at [10m+9:10m] |
| motor_mode | output | 8 | Four 2-bit drive modes, motor m at [2m+1:2m] |
| drib_speed | output | 10 | Dribbler speed |
| drib_mode | output | 2 | Dribbler drive mode |
| kick_charge | output | 1 | Kicker charge enable |
| chip_sel | output | 1 | 1 = chip, 0 = kick |
| kick_power | output | 8 | Kicker pulse strength (0xFF = 6 ms) |

## Verification
Each SPI pin goes through two synchronizer flops and an edge register before the control logic acts on it. A MISO bit therefore settles about three system clocks after the SCK falling edge that launches it. The bench samples MISO eight clocks later, just before the next rising edge. Committed setpoints appear four clocks after the last rising edge of the 12th byte, and telemetry is snapshotted three clocks after chip select falls. The bench checks outputs at least eight clocks after raising chip select, and changes telemetry inputs only after the snapshot point and before the first SCK edge.

// File: rtl/spi_mc_pkg.sv
package spi_mc_pkg;
    localparam logic [7:0] CMD_READ   = 8'h00;
    localparam logic [7:0] CMD_WRITE  = 8'h01;
    localparam logic [7:0] FW_VERSION = 8'h04;
    localparam int SPEED_W = 10;   // 8 low bits + 2 high bits per packed pair
    localparam int MODE_W  = 2;
endpackage

// File: rtl/spi_mc_sync.sv
module spi_mc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_fall,
    output logic cs_active,
    output logic mosi_s
);
    logic [STAGES-1:0] sclk_q, cs_q, mosi_q;
    logic              sclk_prev_q, cs_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q      <= '0;
            cs_q        <= '1;
            mosi_q      <= '0;
            sclk_prev_q <= 1'b0;
            cs_prev_q   <= 1'b1;
        end else begin
            sclk_q      <= {sclk_q[STAGES-2:0], sclk};
            cs_q        <= {cs_q[STAGES-2:0], cs_n};
            mosi_q      <= {mosi_q[STAGES-2:0], mosi};
            sclk_prev_q <= sclk_q[STAGES-1];
            cs_prev_q   <= cs_q[STAGES-1];
        end
    end

    assign sclk_rise = sclk_q[STAGES-1] & ~sclk_prev_q;
    assign sclk_fall = ~sclk_q[STAGES-1] & sclk_prev_q;
    assign cs_fall   = ~cs_q[STAGES-1] & cs_prev_q;
    assign cs_active = ~cs_q[STAGES-1];
    assign mosi_s    = mosi_q[STAGES-1];
endmodule

// File: rtl/spi_mc_tlm_pack.sv
module spi_mc_tlm_pack
    import spi_mc_pkg::*;
#(
    parameter int NUM_ENC  = 4,
    parameter int NUM_HALL = 5,
    localparam int TLM_BYTES = 1 + 2*NUM_ENC + 3 + NUM_HALL
) (
    input  logic [NUM_ENC*16-1:0]  enc_counts,
    input  logic [7:0]             motor_fault,
    input  logic [7:0]             kick_status,
    input  logic [7:0]             kick_volt,
    input  logic [NUM_HALL*8-1:0]  hall_counts,
    output logic [TLM_BYTES*8-1:0] frame
);
    localparam int MISC_BASE = 1 + 2*NUM_ENC;

    assign frame[7:0] = FW_VERSION;

    for (genvar e = 0; e < NUM_ENC; e++) begin : g_enc
        assign frame[(1+2*e)*8 +: 8] = enc_counts[e*16 +: 8];
        assign frame[(2+2*e)*8 +: 8] = enc_counts[e*16+8 +: 8];
    end

    assign frame[MISC_BASE*8 +: 8]     = motor_fault;
    assign frame[(MISC_BASE+1)*8 +: 8] = kick_status;
    assign frame[(MISC_BASE+2)*8 +: 8] = kick_volt;

    for (genvar h = 0; h < NUM_HALL; h++) begin : g_hall
        assign frame[(MISC_BASE+3+h)*8 +: 8] = hall_counts[h*8 +: 8];
    end
endmodule

// File: rtl/spi_mc_decode.sv
module spi_mc_decode
    import spi_mc_pkg::*;
#(
    parameter int NUM_MOT = 4,
    localparam int DATA_BYTES = 2*(NUM_MOT+1) + 1
) (
    input  logic [DATA_BYTES*8-1:0]     shadow,
    output logic [NUM_MOT*SPEED_W-1:0]  speed,
    output logic [NUM_MOT*MODE_W-1:0]   mode,
    output logic [SPEED_W-1:0]          drib_speed,
    output logic [MODE_W-1:0]           drib_mode,
    output logic                        charge,
    output logic                        chip,
    output logic [7:0]                  power
);
    localparam int DRIB = 2*NUM_MOT;

    for (genvar m = 0; m < NUM_MOT; m++) begin : g_mot
        assign speed[m*SPEED_W +: SPEED_W] = {shadow[(2*m+1)*8 +: 2], shadow[(2*m)*8 +: 8]};
        assign mode[m*MODE_W +: MODE_W]    = shadow[(2*m+1)*8+2 +: 2];
    end

    assign drib_speed = {shadow[(DRIB+1)*8 +: 2], shadow[DRIB*8 +: 8]};
    assign drib_mode  = shadow[(DRIB+1)*8+2 +: 2];
    assign charge     = shadow[(DRIB+1)*8+7];
    assign chip       = shadow[(DRIB+1)*8+6];
    assign power      = shadow[(DRIB+2)*8 +: 8];
endmodule

// File: rtl/spi_mc_slave.sv
module spi_mc_slave
    import spi_mc_pkg::*;
#(
    parameter int NUM_ENC     = 4,
    parameter int NUM_HALL    = 5,
    parameter int NUM_MOT     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sclk,
    input  logic                        cs_n,
    input  logic                        mosi,
    output logic                        miso,
    input  logic [NUM_ENC*16-1:0]       enc_counts,
    input  logic [7:0]                  motor_fault,
    input  logic [7:0]                  kick_status,
    input  logic [7:0]                  kick_volt,
    input  logic [NUM_HALL*8-1:0]       hall_counts,
    output logic [NUM_MOT*SPEED_W-1:0]  motor_speed,
    output logic [NUM_MOT*MODE_W-1:0]   motor_mode,
    output logic [SPEED_W-1:0]          drib_speed,
    output logic [MODE_W-1:0]           drib_mode,
    output logic                        kick_charge,
    output logic                        chip_sel,
    output logic [7:0]                  kick_power
);
    localparam int TLM_BYTES  = 1 + 2*NUM_ENC + 3 + NUM_HALL;
    localparam int DATA_BYTES = 2*(NUM_MOT+1) + 1;
    localparam int WR_BYTES   = DATA_BYTES + 1;
    localparam int CNT_W      = $clog2(TLM_BYTES + 2);
    localparam int OUT_W      = NUM_MOT*(SPEED_W+MODE_W) + SPEED_W + MODE_W + 10;
    localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_BYTES - 1);
    localparam logic [CNT_W-1:0] TLM_N   = CNT_W'(TLM_BYTES);

    typedef struct packed {
        logic [2:0]                  bit_cnt;
        logic [CNT_W-1:0]            byte_cnt;
        logic [7:0]                  shift_in;
        logic [7:0]                  cmd;
        logic [7:0]                  shift_out;
        logic                        miso;
        logic [TLM_BYTES*8-1:0]      snap;
        logic [DATA_BYTES*8-1:0]     shadow;
        logic                        commit;
        logic [NUM_MOT*SPEED_W-1:0]  speed;
        logic [NUM_MOT*MODE_W-1:0]   mode;
        logic [SPEED_W-1:0]          drib_speed;
        logic [MODE_W-1:0]           drib_mode;
        logic                        charge;
        logic                        chip;
        logic [7:0]                  power;
    } state_t;

    state_t state_d, state_q;

    logic sclk_rise, sclk_fall, cs_fall, cs_active, mosi_s;
    logic [TLM_BYTES*8-1:0]     frame_now;
    logic [NUM_MOT*SPEED_W-1:0] dec_speed;
    logic [NUM_MOT*MODE_W-1:0]  dec_mode;
    logic [SPEED_W-1:0]         dec_drib_speed;
    logic [MODE_W-1:0]          dec_drib_mode;
    logic                       dec_charge, dec_chip;
    logic [7:0]                 dec_power;
    logic [7:0]                 byte_in;
    logic                       next_is_read;
    logic [TLM_BYTES*8-1:0]     snap_shifted;

    spi_mc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_fall(cs_fall),
        .cs_active(cs_active), .mosi_s(mosi_s)
    );

    spi_mc_tlm_pack #(.NUM_ENC(NUM_ENC), .NUM_HALL(NUM_HALL)) u_pack (
        .enc_counts(enc_counts), .motor_fault(motor_fault), .kick_status(kick_status),
        .kick_volt(kick_volt), .hall_counts(hall_counts), .frame(frame_now)
    );

    spi_mc_decode #(.NUM_MOT(NUM_MOT)) u_decode (
        .shadow(state_q.shadow), .speed(dec_speed), .mode(dec_mode),
        .drib_speed(dec_drib_speed), .drib_mode(dec_drib_mode),
        .charge(dec_charge), .chip(dec_chip), .power(dec_power)
    );

    assign byte_in      = {state_q.shift_in[6:0], mosi_s};
    assign next_is_read = (state_q.byte_cnt == '0) ? (byte_in == CMD_READ)
                                                   : (state_q.cmd == CMD_READ);
    assign snap_shifted = state_q.snap >> {state_q.byte_cnt, 3'b000};

    always_comb begin
        state_d        = state_q;
        state_d.commit = 1'b0;

        if (state_q.commit) begin
            state_d.speed      = dec_speed;
            state_d.mode       = dec_mode;
            state_d.drib_speed = dec_drib_speed;
            state_d.drib_mode  = dec_drib_mode;
            state_d.charge     = dec_charge;
            state_d.chip       = dec_chip;
            state_d.power      = dec_power;
        end

        if (cs_fall) begin
            state_d.bit_cnt   = '0;
            state_d.byte_cnt  = '0;
            state_d.shift_out = '0;
            state_d.miso      = 1'b0;
            state_d.snap      = frame_now;
        end else if (!cs_active) begin
            state_d.miso = 1'b0;
        end else begin
            if (sclk_rise) begin
                state_d.shift_in = byte_in;
                state_d.bit_cnt  = state_q.bit_cnt + 3'd1;
                if (state_q.bit_cnt == 3'd7) begin
                    if (state_q.byte_cnt == '0) begin
                        state_d.cmd = byte_in;
                    end else if (state_q.cmd == CMD_WRITE && state_q.byte_cnt <= WR_LAST) begin
                        for (int k = 0; k < DATA_BYTES; k++) begin
                            if (state_q.byte_cnt == CNT_W'(k + 1)) begin
                                state_d.shadow[k*8 +: 8] = byte_in;
                            end
                        end
                        state_d.commit = (state_q.byte_cnt == WR_LAST);
                    end
                    if (state_q.byte_cnt != '1) begin
                        state_d.byte_cnt = state_q.byte_cnt + 1'b1;
                    end
                    if (next_is_read && state_q.byte_cnt < TLM_N) begin
                        state_d.shift_out = snap_shifted[7:0];
                    end else begin
                        state_d.shift_out = '0;
                    end
                end
            end
            if (sclk_fall) begin
                state_d.miso      = state_q.shift_out[7];
                state_d.shift_out = {state_q.shift_out[6:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign miso        = state_q.miso;
    assign motor_speed = state_q.speed;
    assign motor_mode  = state_q.mode;
    assign drib_speed  = state_q.drib_speed;
    assign drib_mode   = state_q.drib_mode;
    assign kick_charge = state_q.charge;
    assign chip_sel    = state_q.chip;
    assign kick_power  = state_q.power;
endmodule

// File: rtl/spi_mc_checker.sv
module spi_mc_checker #(
    parameter int CNT_W = 5,
    parameter int OUT_W = 60
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             miso,
    input logic             cs_fall,
    input logic             commit,
    input logic [7:0]       cmd,
    input logic [CNT_W-1:0] byte_cnt,
    input logic [OUT_W-1:0] outs
);
    // MISO is quiet once chip select has been high long enough to pass the synchronizer
    assert_miso_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso);

    // Setpoint outputs move only on the cycle after a commit
    assert_outputs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(outs));

    // A commit can only come from a write command
    assert_commit_write_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (cmd == 8'h01));

    // Chip select falling restarts byte counting, dropping any partial frame
    assert_frame_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (byte_cnt == '0));
endmodule

bind spi_mc_slave spi_mc_checker #(.CNT_W(CNT_W), .OUT_W(OUT_W)) u_checker (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso(miso), .cs_fall(cs_fall),
    .commit(state_q.commit), .cmd(state_q.cmd), .byte_cnt(state_q.byte_cnt),
    .outs({motor_speed, motor_mode, drib_speed, drib_mode, kick_charge, chip_sel, kick_power})
);

// File: tb/test_spi_mc_slave.sv
module test_spi_mc_slave;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso;
    logic [63:0] enc_counts = '0;
    logic [7:0]  motor_fault = '0, kick_status = '0, kick_volt = '0;
    logic [39:0] hall_counts = '0;
    logic [39:0] motor_speed;
    logic [7:0]  motor_mode;
    logic [9:0]  drib_speed;
    logic [1:0]  drib_mode;
    logic        kick_charge, chip_sel;
    logic [7:0]  kick_power;

    int checks = 0;
    int fails  = 0;

    // bench-side setpoint model
    logic [9:0] e_spd [5];
    logic [1:0] e_md  [5];
    logic       e_chg, e_chip;
    logic [7:0] e_pwr;
    logic [7:0] txb [13];

    always #4 clk = ~clk;

    spi_mc_slave i_spi_mc_slave (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
        .enc_counts(enc_counts), .motor_fault(motor_fault), .kick_status(kick_status),
        .kick_volt(kick_volt), .hall_counts(hall_counts), .motor_speed(motor_speed),
        .motor_mode(motor_mode), .drib_speed(drib_speed), .drib_mode(drib_mode),
        .kick_charge(kick_charge), .chip_sel(chip_sel), .kick_power(kick_power)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = miso;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic cs_begin();
        cs_n = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic cs_end();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    // build a 12-byte write frame from the model, reserved bits set to ones
    task automatic build_write(input int seed);
        for (int m = 0; m < 5; m++) begin
            e_spd[m] = 10'(seed * 97 + m * 211 + 3);
            e_md[m]  = 2'(seed + m);
        end
        e_chg  = seed[0];
        e_chip = ~seed[0];
        e_pwr  = 8'(seed * 37 + 5);
        txb[0] = 8'h01;
        for (int m = 0; m < 4; m++) begin
            txb[1+2*m] = e_spd[m][7:0];
            txb[2+2*m] = {4'hF, e_md[m], e_spd[m][9:8]};
        end
        txb[9]  = e_spd[4][7:0];
        txb[10] = {e_chg, e_chip, 2'b11, e_md[4], e_spd[4][9:8]};
        txb[11] = e_pwr;
        txb[12] = 8'hA5;
    endtask

    task automatic check_outputs(input string req);
        for (int m = 0; m < 4; m++) begin
            check({req, " speed"}, 32'(motor_speed[m*10 +: 10]), 32'(e_spd[m]));
            check({req, " mode"},  32'(motor_mode[m*2 +: 2]),    32'(e_md[m]));
        end
        check({req, " drib speed"}, 32'(drib_speed), 32'(e_spd[4]));
        check({req, " drib mode"},  32'(drib_mode),  32'(e_md[4]));
        check({req, " charge"},     32'(kick_charge), 32'(e_chg));
        check({req, " chip"},       32'(chip_sel),    32'(e_chip));
        check({req, " power"},      32'(kick_power),  32'(e_pwr));
    endtask

    function automatic logic [7:0] tlm_byte(input int i, input logic [63:0] enc,
            input logic [7:0] f, input logic [7:0] s, input logic [7:0] v, input logic [39:0] h);
        if (i == 0) return 8'h04;
        if (i <= 8) return enc[(i-1)*8 +: 8];
        if (i == 9) return f;
        if (i == 10) return s;
        if (i == 11) return v;
        return h[(i-12)*8 +: 8];
    endfunction

    task automatic test_reset();
        check("R1 speeds", 32'(motor_speed != 0), 0);
        check("R1 modes",  32'(motor_mode), 0);
        check("R1 dribbler", 32'({drib_speed, drib_mode}), 0);
        check("R1 kicker", 32'({kick_charge, chip_sel, kick_power}), 0);
        check("R1 miso", 32'(miso), 0);
    endtask

    task automatic test_write_full();
        logic [7:0] rx;
        build_write(1);
        cs_begin();
        for (int b = 0; b < 12; b++) spi_byte(txb[b], rx);
        cs_end();
        check_outputs("R4/R5 decode");
    endtask

    task automatic test_commit_point();
        logic [7:0] rx;
        logic [9:0] old0;
        old0 = e_spd[0];
        build_write(2);
        cs_begin();
        for (int b = 0; b < 11; b++) spi_byte(txb[b], rx);
        repeat (12) @(negedge clk);
        check("R6 no commit before last byte", 32'(motor_speed[9:0]), 32'(old0));
        spi_byte(txb[11], rx);
        repeat (8) @(negedge clk);
        check_outputs("R6 commit on byte 12");
        cs_end();
    endtask

    task automatic test_extra_bytes();
        logic [7:0] rx;
        build_write(3);
        cs_begin();
        for (int b = 0; b < 13; b++) spi_byte(txb[b], rx);
        spi_byte(8'h3C, rx);
        cs_end();
        check_outputs("R6 extra bytes ignored");
    endtask

    task automatic test_abort();
        logic [7:0] rx;
        cs_begin();
        spi_byte(8'h01, rx);
        for (int b = 0; b < 6; b++) spi_byte(8'hEE, rx);
        cs_end();
        check_outputs("R7 aborted frame");
    endtask

    task automatic test_unknown();
        logic [7:0] rx;
        logic [7:0] acc;
        acc = '0;
        cs_begin();
        spi_byte(8'h5A, rx);
        for (int b = 0; b < 11; b++) begin
            spi_byte(8'hFF, rx);
            acc = acc | rx;
        end
        cs_end();
        check("R9 miso zeros", 32'(acc), 0);
        check_outputs("R9 outputs unchanged");
    endtask

    task automatic test_read();
        logic [7:0] rx;
        enc_counts  = 64'h8877_6655_4433_2211;
        motor_fault = 8'h9A; kick_status = 8'hC3; kick_volt = 8'h7E;
        hall_counts = 40'hE5_D4_C3_B2_A1;
        cs_begin();
        spi_byte(8'h00, rx);
        check("R3 command byte miso", 32'(rx), 0);
        for (int i = 0; i < 17; i++) begin
            spi_byte(8'h00, rx);
            check($sformatf("R2/R10 telemetry byte %0d", i), 32'(rx),
                  32'(tlm_byte(i, enc_counts, motor_fault, kick_status, kick_volt, hall_counts)));
        end
        spi_byte(8'h00, rx);
        check("R3 past frame end", 32'(rx), 0);
        cs_end();
        check("R3 idle miso", 32'(miso), 0);
    endtask

    task automatic test_snapshot();
        logic [7:0]  rx;
        logic [63:0] enc0;
        logic [39:0] hall0;
        logic [7:0]  f0, s0, v0;
        enc_counts  = 64'h12FF_3400_56AB_78CD;
        motor_fault = 8'h01; kick_status = 8'h02; kick_volt = 8'h03;
        hall_counts = 40'h0A_0B_0C_0D_0E;
        enc0 = enc_counts; hall0 = hall_counts;
        f0 = motor_fault; s0 = kick_status; v0 = kick_volt;
        cs_begin();
        enc_counts  = ~enc0;
        motor_fault = 8'hF0; kick_volt = 8'h55;
        hall_counts = ~hall0;
        spi_byte(8'h00, rx);
        for (int i = 0; i < 17; i++) begin
            spi_byte(8'h00, rx);
            check($sformatf("R8 snapshot byte %0d", i), 32'(rx),
                  32'(tlm_byte(i, enc0, f0, s0, v0, hall0)));
        end
        cs_end();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        test_reset();
        test_write_full();
        test_commit_point();
        test_extra_bytes();
        test_abort();
        test_unknown();
        test_read();
        test_snapshot();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule